// File: doc/BRIEF.md
# Serial Flash Byte Shifter

This block is the shifting engine behind a pair of software-visible registers for a serial configuration flash. Software loads a data word and then writes an operation word, which starts one transfer of one to four bytes over a mode-0 SPI link. The operation word picks the direction (send the data word or capture into it), the byte count, and whether chip select is held low once the transfer ends.

Holding chip select lets a complete flash command be built from several short transfers. For example, a read command is built as follows. First, one four-byte send carries the opcode (11) in the low byte and the byte-swapped 24-bit address in the upper three bytes. Next comes a one-byte receive for the dummy byte. Last, one or more receives collect the data. Bytes always leave and arrive through the least significant lane first. The SPI clock is half the system clock. While a transfer runs, the block raises a busy flag and ignores further register writes.

Top module: `sflash_shifter`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sck is 0, spi_mosi is 0, busy is 0 and data_q is 0.
- R2: An operation write with bit 0 = 1 sends N = bits[2:1]+1 bytes of data_q: lane 0 (bits 7:0) first, then lane 1 and so on, each byte most significant bit first, with spi_mosi changing only while spi_sck is low.
- R3: An operation write with bit 0 = 0 receives N = bits[2:1]+1 bytes, sampling spi_miso on each rising spi_sck. The first byte lands in lane 0, each byte is assembled MSB first, and every lane at or above N reads 0.
- R4: busy is 1 from the clock edge that accepts the operation write for exactly 16*N system clock cycles (spi_sck = clk/2), then returns to 0.
- R5: With operation bit 3 set, spi_cs_n stays 0 after the transfer. A following transfer then continues the same flash command without a chip-select pulse.
- R6: With operation bit 3 clear, spi_cs_n returns to 1 on the same edge that clears busy. The next transfer drives it low again and starts a new command.
- R7: While busy is 1, writes to the operation word and to the data word have no effect. The running transfer keeps its length and its data, and no extra transfer follows.
- R8: spi_sck is 0 whenever busy is 0, and no spi_sck edge occurs while idle.
- R9: A send transfer leaves data_q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data word |
| op_wr | input | 1 | Write strobe for the operation word; starts a transfer |
| wdata | input | 32 | Write value for either register |
| data_q | output | 32 | Data word: the send source and the receive destination |
| busy | output | 1 | Transfer in progress |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Sends of one and of four bytes use byte values whose lanes all differ. A swapped lane order, or LSB-first shifting, therefore shows up in the serial stream the flash model records. Receives of two and of four bytes are taken from a flash model with a distinct byte at each position, starting over a preset all-ones word. This tells correct lane placement apart from stale bits left above the byte count. A held-select read sequence (command word, dummy byte, data) separates a chip select that stays low from one that pulses, because the model restarts its byte stream on every select edge. A second operation and a data write issued mid-transfer show whether a busy transfer can be stretched, restarted or corrupted.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   // direction field value (operation word bit 0)
   typedef enum logic {
      SFS_DIR_RX = 1'b0,
      SFS_DIR_TX = 1'b1
   } sfs_dir_e;

   // bit position of the direction field in the operation word
   localparam int SFS_DIR_POS = 0;
   // lowest bit of the byte-count-minus-one field
   localparam int SFS_CNT_LSB = 1;
   // bits per byte lane
   localparam int SFS_LANE_W  = 8;
endpackage

// File: rtl/sfs_halfclk.sv
module sfs_halfclk #(
   parameter int HALF = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   initial begin
      assert (HALF >= 1) else $error("sfs_halfclk: HALF must be at least 1");
   end

   generate
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (!run)                       cnt_q <= '0;
            else if (cnt_q == CW'(HALF - 1))     cnt_q <= '0;
            else                                 cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run && (cnt_q == CW'(HALF - 1));
      end
   endgenerate
endmodule

// File: rtl/sfs_engine.sv
module sfs_engine #(
   parameter int BIT_W = 5,
   parameter int HALF  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cont_in,
   input  logic [BIT_W-1:0] last_idx,
   output logic             busy,
   output logic             sck,
   output logic             cs_n,
   output logic [BIT_W-1:0] bit_idx,
   output logic             sample
);
   logic             tick;
   logic             cont_q;
   logic [BIT_W-1:0] last_q;

   sfs_halfclk #(.HALF(HALF)) u_halfclk (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         bit_idx <= '0;
         cont_q  <= 1'b0;
         last_q  <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         sck     <= 1'b0;
         cs_n    <= 1'b0;
         bit_idx <= '0;
         cont_q  <= cont_in;
         last_q  <= last_idx;
      end else if (busy && tick) begin
         if (!sck) begin
            sck <= 1'b1;
         end else begin
            sck <= 1'b0;
            if (bit_idx == last_q) begin
               busy <= 1'b0;
               cs_n <= ~cont_q;
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end
      end
   end

   assign sample = busy && tick && !sck;

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck); // R8

   AST_CS_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n); // R5

   AST_CS_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $fell(busy)); // R6

   AST_IDX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bit_idx <= last_q)); // R4
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter #(
   parameter int WORD_BYTES = 4,
   parameter int CLK_DIV    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      data_wr,
   input  logic                      op_wr,
   input  logic [WORD_BYTES*8-1:0]   wdata,
   output logic [WORD_BYTES*8-1:0]   data_q,
   output logic                      busy,
   output logic                      spi_sck,
   output logic                      spi_mosi,
   output logic                      spi_cs_n,
   input  logic                      spi_miso
);
   import sfs_pkg::*;

   localparam int WORD_W   = WORD_BYTES * SFS_LANE_W;
   localparam int BIT_W    = $clog2(WORD_W);
   localparam int CNT_W    = $clog2(WORD_BYTES);
   localparam int CONT_POS = SFS_CNT_LSB + CNT_W;
   localparam int HALF     = CLK_DIV / 2;

   initial begin
      assert (WORD_BYTES >= 2 && (WORD_BYTES & (WORD_BYTES - 1)) == 0)
         else $error("sflash_shifter: WORD_BYTES must be a power of two >= 2");
      assert (CLK_DIV >= 2 && CLK_DIV % 2 == 0)
         else $error("sflash_shifter: CLK_DIV must be even and >= 2");
      assert (CONT_POS < WORD_W)
         else $error("sflash_shifter: operation fields exceed the word");
   end

   logic             start;
   logic             dir_tx_q;
   logic [CNT_W-1:0] op_cnt;
   logic [BIT_W-1:0] last_idx;
   logic [BIT_W-1:0] bit_idx;
   logic [BIT_W-1:0] sel;
   logic             sample;

   assign start    = op_wr && !busy;
   assign op_cnt   = wdata[SFS_CNT_LSB +: CNT_W];
   assign last_idx = {op_cnt, 3'b111};
   // lane-major, MSB-first bit order inside each byte
   assign sel      = bit_idx ^ BIT_W'(SFS_LANE_W - 1);

   sfs_engine #(.BIT_W(BIT_W), .HALF(HALF)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cont_in (wdata[CONT_POS]),
      .last_idx(last_idx),
      .busy    (busy),
      .sck     (spi_sck),
      .cs_n    (spi_cs_n),
      .bit_idx (bit_idx),
      .sample  (sample)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dir_tx_q <= 1'b0;
      else if (start) dir_tx_q <= wdata[SFS_DIR_POS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (start && (wdata[SFS_DIR_POS] == SFS_DIR_RX)) begin
         data_q <= '0;
      end else if (data_wr && !busy) begin
         data_q <= wdata;
      end else if (sample && (dir_tx_q == SFS_DIR_RX)) begin
         data_q[sel] <= spi_miso;
      end
   end

   assign spi_mosi = busy && (dir_tx_q == SFS_DIR_TX) && data_q[sel];

   AST_TX_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dir_tx_q) |=> $stable(data_q)); // R9

   AST_BUSY_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_wr) |=> $stable(dir_tx_q)); // R7

   AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_mosi); // R1

   AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && spi_sck) |-> $stable(spi_mosi)); // R2
endmodule

// File: tb/sflash_shifter_tb.sv
module sflash_shifter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        data_wr = 1'b0;
   logic        op_wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] data_q;
   logic        busy, spi_sck, spi_mosi, spi_cs_n, spi_miso;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 clk = ~clk;   // 250 MHz

   sflash_shifter dut_i (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .op_wr(op_wr),
      .wdata(wdata), .data_q(data_q), .busy(busy), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
   );

   // ---------------- flash model ----------------
   int          fall_cnt = 0;
   int          fall_base = 0;
   int          rise_cnt = 0;
   logic [31:0] tx_log = '0;

   function automatic logic [7:0] pat(int k);
      return 8'((k * 37 + 11) & 255);
   endfunction

   always @(negedge spi_sck) fall_cnt = fall_cnt + 1;
   always @(negedge spi_cs_n) fall_base = fall_cnt;
   always @(posedge spi_sck) begin
      tx_log   = {tx_log[30:0], spi_mosi};
      rise_cnt = rise_cnt + 1;
   end

   always_comb begin
      automatic int p = fall_cnt - fall_base;
      automatic logic [7:0] b = pat(p >> 3);
      spi_miso = b[7 - (p & 7)];
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rx(int first, int n);
      logic [31:0] w = '0;
      for (int i = 0; i < n; i++) w[i*8 +: 8] = pat(first + i);
      return w;
   endfunction

   task automatic write_data(input logic [31:0] v);
      @(negedge clk); data_wr = 1'b1; wdata = v;
      @(negedge clk); data_wr = 1'b0;
   endtask

   // issues an operation and returns how many cycles busy stayed high
   task automatic xfer(input logic [31:0] op, output int cycles);
      @(negedge clk); op_wr = 1'b1; wdata = op;
      @(negedge clk); op_wr = 1'b0;
      cycles = 0;
      while (busy && cycles < 2000) begin
         @(negedge clk); cycles++;
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(spi_cs_n == 1'b1, "R1 cs_n", 32'(spi_cs_n), 32'd1);
      chk(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 sck/mosi",
          {30'd0, spi_sck, spi_mosi}, 32'd0);
      chk(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
      chk(data_q == 32'd0, "R1 data", data_q, 32'd0);
   endtask

   task automatic t_tx4;
      int c; int r0;
      write_data(32'hA1B2C3D4);
      r0 = rise_cnt;
      xfer(32'h0000_0007, c);
      chk(c == 64, "R4 busy length 4 bytes", 32'(c), 32'd64);
      chk(rise_cnt - r0 == 32, "R2 bit count 4 bytes", 32'(rise_cnt - r0), 32'd32);
      chk(tx_log == 32'hD4C3B2A1, "R2 lane order tx", tx_log, 32'hD4C3B2A1);
      chk(spi_cs_n == 1'b1, "R6 cs released", 32'(spi_cs_n), 32'd1);
      chk(data_q == 32'hA1B2C3D4, "R9 data kept after tx", data_q, 32'hA1B2C3D4);
   endtask

   task automatic t_tx1;
      int c; int r0;
      write_data(32'hCAFE_005A);
      r0 = rise_cnt;
      xfer(32'h0000_0001, c);
      chk(c == 16, "R4 busy length 1 byte", 32'(c), 32'd16);
      chk(rise_cnt - r0 == 8, "R2 bit count 1 byte", 32'(rise_cnt - r0), 32'd8);
      chk(tx_log[7:0] == 8'h5A, "R2 single byte MSB first", 32'(tx_log[7:0]), 32'h5A);
   endtask

   task automatic t_rx2;
      int c;
      write_data(32'hFFFF_FFFF);
      xfer(32'h0000_0002, c);
      chk(c == 32, "R4 busy length 2 bytes", 32'(c), 32'd32);
      chk(data_q == exp_rx(0, 2), "R3 rx 2 bytes, upper lanes zero",
          data_q, exp_rx(0, 2));
      chk(spi_cs_n == 1'b1, "R6 cs released after rx", 32'(spi_cs_n), 32'd1);
   endtask

   task automatic t_read_cmd;
      int c; int r0;
      write_data(32'h0001_000B);          // opcode 11, address 0x000100
      r0 = rise_cnt;
      xfer(32'h0000_000F, c);             // tx, 4 bytes, hold select
      chk(tx_log == 32'h0B00_0100, "R2 command word order", tx_log, 32'h0B000100);
      chk(spi_cs_n == 1'b0, "R5 cs held after command", 32'(spi_cs_n), 32'd0);
      xfer(32'h0000_0008, c);             // rx dummy byte, hold select
      chk(data_q == exp_rx(4, 1), "R5 dummy byte continues stream",
          data_q, exp_rx(4, 1));
      chk(spi_cs_n == 1'b0, "R5 cs held after dummy", 32'(spi_cs_n), 32'd0);
      xfer(32'h0000_0006, c);             // rx 4 bytes, release
      chk(data_q == exp_rx(5, 4), "R3 rx 4 bytes in lanes", data_q, exp_rx(5, 4));
      chk(spi_cs_n == 1'b1, "R6 cs released at end", 32'(spi_cs_n), 32'd1);
      chk(rise_cnt - r0 == 72, "R5 total bits in command", 32'(rise_cnt - r0), 32'd72);
   endtask

   task automatic t_busy_ignore;
      int c; int r0;
      write_data(32'h0000_00C3);
      r0 = rise_cnt;
      @(negedge clk); op_wr = 1'b1; wdata = 32'h0000_0001;
      @(negedge clk); op_wr = 1'b0;
      repeat (3) @(negedge clk);
      op_wr = 1'b1; data_wr = 1'b1; wdata = 32'h1234_5676;
      @(negedge clk); op_wr = 1'b0; data_wr = 1'b0;
      c = 4;
      while (busy && c < 2000) begin
         @(negedge clk); c++;
      end
      chk(c == 16, "R7 length unchanged by busy write", 32'(c), 32'd16);
      chk(data_q == 32'h0000_00C3, "R7 data write ignored while busy",
          data_q, 32'h000000C3);
      chk(tx_log[7:0] == 8'hC3, "R7 sent byte intact", 32'(tx_log[7:0]), 32'hC3);
      repeat (10) @(negedge clk);
      chk(busy == 1'b0 && rise_cnt - r0 == 8, "R7 no extra transfer",
          32'(rise_cnt - r0), 32'd8);
   endtask

   task automatic t_idle;
      int r0;
      r0 = rise_cnt;
      repeat (20) @(negedge clk);
      chk(rise_cnt == r0, "R8 no sck edges idle", 32'(rise_cnt - r0), 32'd0);
      chk(spi_sck == 1'b0, "R8 sck idle low", 32'(spi_sck), 32'd0);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_tx4();
      t_tx1();
      t_rx2();
      t_read_cmd();
      t_busy_ignore();
      t_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule